// File: doc/BRIEF.md
# JK-Excited Six-State Sequence Counter

This block is a 3-bit synchronous counter with six states. It does not count in binary. On every rising clock edge it moves through the closed loop 0, 6, 5, 3, 2, 1 and then returns to 0. Each state bit is held in a JK storage cell, and all cells share one clock. A small combinational stage computes the J and K inputs of every cell from the present state. No adder is involved.

The counter has two inputs: a clock and an active-high synchronous reset. The count leaves the block straight from the storage cells, so it is registered. The per-bit J and K vectors are also brought out, so that the excitation can be observed. The codes 4 and 7 are never reached in normal operation. They are still decoded: a counter that lands on either one returns to 0 on the next edge and cannot get stuck.

Top module: `seqcnt_top`

## Requirements
- R1: With reset low, each rising edge moves the count from 0 to 6, from 6 to 5, from 5 to 3, from 3 to 2, from 2 to 1, and from 1 back to 0.
- R2: When reset is sampled high at a rising edge, the count is 0 after that edge. This holds whatever the present state is, and reset overrides the sequence for as long as it stays high.
- R3: If the count holds code 4 or code 7, the next rising edge with reset low brings it to 0.
- R4: Each count bit b obeys JK rules at every edge with reset low. With {j_o[b],k_o[b]} = 00 the bit holds. With 01 it clears to 0. With 10 it sets to 1. With 11 it inverts.
- R5: The excitation outputs match the R1/R3 successor of the present count. For a bit that is 0, j_o[b] equals that bit of the successor. For a bit that is 1, k_o[b] equals the inverse of that bit of the successor.
- R6: After reset is released, the count sequence repeats with a period of exactly six edges. All six values within one period are distinct, and codes 4 and 7 never appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all state cells |
| rst | input | 1 | Synchronous reset, active high, forces count to 0 |
| count_o | output | 3 | Registered present state |
| j_o | output | 3 | Per-bit J excitation derived from the present state |
| k_o | output | 3 | Per-bit K excitation derived from the present state |

## Verification
The hardest case to reach is the recovery from codes 4 and 7. No input sequence on the ports can ever place the counter in those codes. To get there, the bench keeps reset high, overrides the state register with the unused code for part of one cycle, releases it, and then drops reset before the next edge. The edge that follows therefore starts from the illegal code, with no reset in effect. The scoreboard skips the one comparison that the override disturbs, and then expects 0 under R3. It also checks that the J/K outputs seen in the illegal state predict that return.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;

  localparam int CNT_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  // legal loop, in visiting order
  localparam cnt_t CODE_A = 3'd0;
  localparam cnt_t CODE_B = 3'd6;
  localparam cnt_t CODE_C = 3'd5;
  localparam cnt_t CODE_D = 3'd3;
  localparam cnt_t CODE_E = 3'd2;
  localparam cnt_t CODE_F = 3'd1;

  // codes outside the loop
  localparam cnt_t CODE_X4 = 3'd4;
  localparam cnt_t CODE_X7 = 3'd7;

endpackage

// File: rtl/seqcnt_excite.sv
module seqcnt_excite
  import seqcnt_pkg::*;
(
  input  cnt_t q_i,
  output cnt_t j_o,
  output cnt_t k_o
);

  logic b2, b1, b0;

  always_comb begin
    b2 = q_i[2];
    b1 = q_i[1];
    b0 = q_i[0];

    // bit 2: sets only from 000, holds only in 110
    j_o[2] = ~b1 & ~b0;
    k_o[2] = ~b1 | b0;

    // bit 1: sets from 000 and 101, holds only in 011
    j_o[1] = ~(b2 ^ b0);
    k_o[1] = b2 | ~b0;

    // bit 0: sets from 110 and 010, holds only in 101
    j_o[0] = b1;
    k_o[0] = ~b2 | b1;
  end

endmodule

// File: rtl/seqcnt_jk_bank.sv
module seqcnt_jk_bank #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] j_i,
  input  logic [WIDTH-1:0] k_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else begin
      for (int b = 0; b < WIDTH; b++) begin
        case ({j_i[b], k_i[b]})
          2'b00:   q_r[b] <= q_r[b];
          2'b01:   q_r[b] <= 1'b0;
          2'b10:   q_r[b] <= 1'b1;
          default: q_r[b] <= ~q_r[b];
        endcase
      end
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/seqcnt_top.sv
module seqcnt_top (
  input  logic                          clk,
  input  logic                          rst,
  output logic [seqcnt_pkg::CNT_W-1:0]  count_o,
  output logic [seqcnt_pkg::CNT_W-1:0]  j_o,
  output logic [seqcnt_pkg::CNT_W-1:0]  k_o
);

  import seqcnt_pkg::*;

  cnt_t state_w;
  cnt_t jx_w;
  cnt_t kx_w;

  seqcnt_excite u_excite (
    .q_i (state_w),
    .j_o (jx_w),
    .k_o (kx_w)
  );

  seqcnt_jk_bank #(
    .WIDTH (CNT_W)
  ) u_bank (
    .clk (clk),
    .rst (rst),
    .j_i (jx_w),
    .k_i (kx_w),
    .q_o (state_w)
  );

  assign count_o = state_w;
  assign j_o     = jx_w;
  assign k_o     = kx_w;

endmodule

// File: rtl/seqcnt_chk.sv
module seqcnt_chk
  import seqcnt_pkg::*;
(
  input logic clk,
  input logic rst,
  input cnt_t count_i,
  input cnt_t j_i,
  input cnt_t k_i
);

  // R1: the legal loop, one step per edge
  p_a_to_b_r1: assert property (@(posedge clk) disable iff (rst)
    count_i == CODE_A |=> count_i == CODE_B);
  p_b_to_c_r1: assert property (@(posedge clk) disable iff (rst)
    count_i == CODE_B |=> count_i == CODE_C);
  p_c_to_d_r1: assert property (@(posedge clk) disable iff (rst)
    count_i == CODE_C |=> count_i == CODE_D);
  p_d_to_e_r1: assert property (@(posedge clk) disable iff (rst)
    count_i == CODE_D |=> count_i == CODE_E);
  p_e_to_f_r1: assert property (@(posedge clk) disable iff (rst)
    count_i == CODE_E |=> count_i == CODE_F);
  p_f_to_a_r1: assert property (@(posedge clk) disable iff (rst)
    count_i == CODE_F |=> count_i == CODE_A);

  // R3: unused codes fall back to the start state
  p_unused_recover_r3: assert property (@(posedge clk) disable iff (rst)
    (count_i == CODE_X4 || count_i == CODE_X7) |=> count_i == CODE_A);

  // R4: each bit follows hold / clear / set / invert
  p_jk_rule_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      count_i == (($past(j_i) & ~$past(count_i)) | (~$past(k_i) & $past(count_i))));

  // R5: a zero bit rises exactly where J was high
  p_rise_by_j_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      (count_i & ~$past(count_i)) == ($past(j_i) & ~$past(count_i)));

  // R5: a one bit falls exactly where K was high
  p_fall_by_k_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      (~count_i & $past(count_i)) == ($past(k_i) & $past(count_i)));

endmodule

bind seqcnt_top seqcnt_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .count_i (count_o),
  .j_i     (j_o),
  .k_i     (k_o)
);

// File: tb/seqcnt_top_tb_top.sv
`timescale 1ns/1ps
module seqcnt_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] count_o;
  logic [2:0] j_o;
  logic [2:0] k_o;

  int errors = 0;
  int checks = 0;

  int    exp_q[$];
  string tag_q[$];
  logic [2:0] model = 3'd0;
  bit   forced_ev = 1'b0;
  bit   pred_v = 1'b0;
  logic [2:0] pred = 3'd0;

  always #2 clk = ~clk;

  seqcnt_top dut_i (
    .clk     (clk),
    .rst     (rst),
    .count_o (count_o),
    .j_o     (j_o),
    .k_o     (k_o)
  );

  // successor per R1 and R3
  function automatic logic [2:0] succ(input logic [2:0] s);
    case (s)
      3'd0:    return 3'd6;
      3'd6:    return 3'd5;
      3'd5:    return 3'd3;
      3'd3:    return 3'd2;
      3'd2:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one edge, push expected count into the scoreboard
  task automatic tick();
    @(posedge clk);
    if (rst) begin
      model = 3'd0;
      tag_q.push_back("R2");
    end else begin
      tag_q.push_back((model == 3'd4 || model == 3'd7) ? "R3" : "R1");
      model = succ(model);
    end
    exp_q.push_back(int'(model));
    #1;
  endtask

  // R5 check on the present state
  task automatic chk_excite();
    logic [2:0] n;
    bit ok;
    n  = succ(count_o);
    ok = 1'b1;
    for (int b = 0; b < 3; b++) begin
      if (count_o[b] == 1'b0 && j_o[b] != n[b]) ok = 1'b0;
      if (count_o[b] == 1'b1 && k_o[b] != ~n[b]) ok = 1'b0;
    end
    chk(ok, "R5", int'({j_o, k_o}), int'(n));
  endtask

  // monitor: pop expected values and compare away from the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (!forced_ev) chk(int'(count_o) == e, t, int'(count_o), e);
    end
    if (pred_v && !forced_ev)
      chk(count_o == pred, "R4", int'(count_o), int'(pred));
    pred      = rst ? 3'd0 : ((j_o & ~count_o) | (~k_o & count_o));
    pred_v    = 1'b1;
    forced_ev = 1'b0;
    chk_excite();
  end

  task automatic inject(input logic [2:0] code);
    rst = 1'b1;
    tick();
    tick();
    force dut_i.u_bank.q_r = code;
    #0.2;
    release dut_i.u_bank.q_r;
    forced_ev = 1'b1;
    model     = code;
    rst       = 1'b0;
    #0.2;
    chk(count_o == code, "R3", int'(count_o), int'(code));
    tick();
    chk(count_o == 3'd0, "R3", int'(count_o), 0);
  endtask

  initial begin
    logic [2:0] seq [12];
    bit ok;

    rst = 1'b1;
    tick();
    tick();
    tick();
    chk(count_o == 3'd0, "R2", int'(count_o), 0);
    rst = 1'b0;

    // R6: period and distinctness over two laps
    for (int i = 0; i < 12; i++) begin
      tick();
      seq[i] = count_o;
    end
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (seq[i] != seq[i+6]) ok = 1'b0;
      if (seq[i] == 3'd4 || seq[i] == 3'd7) ok = 1'b0;
      for (int m = i + 1; m < 6; m++) if (seq[i] == seq[m]) ok = 1'b0;
    end
    chk(ok, "R6", int'(seq[0]), int'(seq[6]));

    // R2: reset in the middle of the loop
    while (count_o != 3'd5) tick();
    rst = 1'b1;
    tick();
    chk(count_o == 3'd0, "R2", int'(count_o), 0);
    tick();
    chk(count_o == 3'd0, "R2", int'(count_o), 0);
    rst = 1'b0;
    tick();
    chk(count_o == 3'd6, "R1", int'(count_o), 6);

    // R3: recovery from both unused codes
    inject(3'd4);
    tick();
    tick();
    inject(3'd7);
    for (int i = 0; i < 8; i++) tick();

    @(negedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule